// File: doc/BRIEF.md
# Pair-Based Rectangular-Window Plasticity Engine

This block keeps the learning state of a fully connected group of `N` neurons and adjusts its synaptic weights by timing-dependent plasticity with a rectangular window. The synapse from neuron `p` (sender) to neuron `q` (receiver) lives at flat address `p*N + q`. Each entry holds five things. There is a signed weight. There is a sender-side age counter, called the arm trace, with its pending bit. There is a receiver-side age counter, called the echo trace. There is a static plasticity-enable bit. A trace value of 0xFF means disabled.

A neuron engine drives the block. It pulses `step` once at the start of every time step. It then reports each neuron that fires in that step by pulsing `spk_valid` with `spk_idx`. The block works through its memories one entry per clock cycle:
- After a step pulse, state `ST_AGE` sweeps every entry and ages the live traces.
- For each queued spike, state `ST_ROW` walks the firing neuron's outgoing row and state `ST_COL` walks its incoming column.
- State `ST_IDLE` waits for the next step pulse or spike.

The transitions are:
- IDLE→AGE on `step`.
- IDLE→ROW when a spike is queued and no step is present.
- AGE→IDLE after the last entry.
- ROW→COL after the last row entry.
- COL→IDLE after the last column entry.

Spikes that arrive while the block is busy are queued and processed in ascending index order. Weights are read out through a combinational port so that the neuron datapath can use them.

Top module: `stdp_updater`

## Requirements
- R1: After reset, every weight equals `INIT_W`, every trace is disabled (0xFF), every pending bit is 0 and `done` is 1. The weight at address `p*N+q` can be read on `wt_rdata` for `wt_raddr = p*N+q`.
- R2: If sender `p` fires in step s and receiver `q` fires in step s+d with 0 < d < `t_pre`, weight `p*N+q` rises by `dw_pos`.
- R3: If receiver `q` fires in step s and sender `p` fires in step s+d with 0 < d < `t_post`, weight `p*N+q` falls by `dw_neg`.
- R4: A trace ages by 1 on each step pulse. When it reaches its window length it becomes 0xFF and its pending bit clears, so d ≥ window gives no change. Spikes in the same step (d = 0) never pair, and a 0xFF trace never ages and never pairs.
- R5: A pairing that changes a weight disables that synapse's trace and clears its pending bit. A later spike of the same receiver therefore gives no second change until the sender fires again.
- R6: Weight changes saturate at the signed limits (+127 / −128 for 8 bits) instead of wrapping.
- R7: A synapse whose enable bit in `PLAST_MASK` (bit `p*N+q`) is 0 keeps its weight unchanged.
- R8: Self synapses (address `k*N+k`) are skipped by row and column walks and never change.
- R9: `done` is 1 only when the block is idle with no spike queued. A step pulse in idle is followed by exactly `N*N` busy cycles, a single spike by exactly `2N+1` busy cycles. A step pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one memory entry per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Start-of-time-step pulse (accepted in idle) |
| spk_valid | input | 1 | A neuron fired this step |
| spk_idx | input | $clog2(N) | Index of the firing neuron |
| dw_pos | input | WB-1 | Potentiation magnitude |
| dw_neg | input | WB-1 | Depression magnitude |
| t_pre | input | TB | Sender-first window length in steps |
| t_post | input | TB | Receiver-first window length in steps |
| wt_raddr | input | $clog2(N*N) | Weight read address, row-major |
| wt_rdata | output | WB | Signed weight at `wt_raddr` |
| done | output | 1 | Idle with an empty spike queue |

## Verification
The bench builds the block with N = 4, 8-bit weights and traces, `INIT_W` = 0, and a mask that freezes only synapse 3→2 (address 14). With N = 4, a step sweep is 16 cycles and a spike walk is 9 cycles, so many steps fit in a short run. A window of 3 steps lets the bench place pairs exactly at d = 0, 1, 2 and 3, which puts both window edges and the same-step case within reach. Raising the magnitudes to 100 drives a weight past both signed limits in two pairings each. Repeated firing of one neuron exercises both trace consumption and the skipped diagonal.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AGE,
        ST_ROW,
        ST_COL
    } stdp_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_AGE,
        OP_ROW,
        OP_COL
    } stdp_op_e;

endpackage

// File: rtl/stdp_spike_queue.sv
module stdp_spike_queue #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_vld,
    input  logic [IW-1:0] set_idx,
    input  logic          take,
    output logic          has_spike,
    output logic [IW-1:0] pick_idx
);

    logic [N-1:0] fired_q;
    logic [N-1:0] set_m;
    logic [N-1:0] clr_m;

    always_comb begin
        pick_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fired_q[i]) pick_idx = IW'(i);
        end
    end

    assign has_spike = |fired_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            assign set_m[g] = set_vld && (int'(set_idx) == g);
            assign clr_m[g] = take && (int'(pick_idx) == g);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fired_q <= '0;
        else        fired_q <= (fired_q & ~clr_m) | set_m;
    end

endmodule

// File: rtl/stdp_pair_unit.sv
module stdp_pair_unit
    import stdp_pkg::*;
#(
    parameter int WB = 8,
    parameter int TB = 8
) (
    input  stdp_op_e              op,
    input  logic                  diag,
    input  logic                  mask,
    input  logic [WB-2:0]         dw_pos,
    input  logic [WB-2:0]         dw_neg,
    input  logic [TB-1:0]         t_pre,
    input  logic [TB-1:0]         t_post,
    input  logic signed [WB-1:0]  w,
    input  logic [TB-1:0]         pre,
    input  logic [TB-1:0]         post,
    input  logic                  pend,
    output logic signed [WB-1:0]  w_n,
    output logic [TB-1:0]         pre_n,
    output logic [TB-1:0]         post_n,
    output logic                  pend_n
);

    localparam logic [TB-1:0] OFF   = '1;
    localparam int            W_MAX = (2 ** (WB - 1)) - 1;
    localparam int            W_MIN = -(2 ** (WB - 1));

    function automatic logic signed [WB-1:0] clamp(input int v);
        if (v > W_MAX)      return WB'(W_MAX);
        else if (v < W_MIN) return WB'(W_MIN);
        else                return WB'(v);
    endfunction

    int pre_inc;
    int post_inc;

    always_comb begin
        w_n      = w;
        pre_n    = pre;
        post_n   = post;
        pend_n   = pend;
        pre_inc  = int'(pre) + 1;
        post_inc = int'(post) + 1;
        unique case (op)
            OP_AGE: begin
                if (pre != OFF) begin
                    if (pre_inc >= int'(t_pre)) begin
                        pre_n  = OFF;
                        pend_n = 1'b0;
                    end else begin
                        pre_n = TB'(pre_inc);
                    end
                end
                if (post != OFF) begin
                    if (post_inc >= int'(t_post)) post_n = OFF;
                    else                          post_n = TB'(post_inc);
                end
            end
            OP_ROW: begin
                if (!diag) begin
                    if (post != OFF && post != '0) begin
                        post_n = OFF;
                        if (mask) w_n = clamp(int'(w) - int'(dw_neg));
                    end
                    pre_n  = '0;
                    pend_n = 1'b1;
                end
            end
            OP_COL: begin
                if (!diag) begin
                    if (pend && pre != OFF && pre != '0) begin
                        pre_n  = OFF;
                        pend_n = 1'b0;
                        if (mask) w_n = clamp(int'(w) + int'(dw_pos));
                    end
                    post_n = '0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stdp_syn_store.sv
module stdp_syn_store #(
    parameter int              N          = 4,
    parameter int              WB         = 8,
    parameter int              TB         = 8,
    parameter int              INIT_W     = 0,
    parameter logic [N*N-1:0]  PLAST_MASK = '1,
    localparam int             NN         = N * N,
    localparam int             AW         = $clog2(NN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 we,
    input  logic signed [WB-1:0] w_wr,
    input  logic [TB-1:0]        pre_wr,
    input  logic [TB-1:0]        post_wr,
    input  logic                 pend_wr,
    output logic signed [WB-1:0] w_rd,
    output logic [TB-1:0]        pre_rd,
    output logic [TB-1:0]        post_rd,
    output logic                 pend_rd,
    output logic                 mask_rd,
    input  logic [AW-1:0]        ext_addr,
    output logic signed [WB-1:0] ext_w
);

    logic signed [WB-1:0] w_mem    [NN];
    logic [TB-1:0]        pre_mem  [NN];
    logic [TB-1:0]        post_mem [NN];
    logic [NN-1:0]        pend_mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NN; i++) begin
                w_mem[i]    <= WB'(INIT_W);
                pre_mem[i]  <= '1;
                post_mem[i] <= '1;
            end
            pend_mem <= '0;
        end else if (we) begin
            w_mem[addr]    <= w_wr;
            pre_mem[addr]  <= pre_wr;
            post_mem[addr] <= post_wr;
            pend_mem[addr] <= pend_wr;
        end
    end

    assign w_rd    = w_mem[addr];
    assign pre_rd  = pre_mem[addr];
    assign post_rd = post_mem[addr];
    assign pend_rd = pend_mem[addr];
    assign mask_rd = PLAST_MASK[addr];
    assign ext_w   = w_mem[ext_addr];

endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
    import stdp_pkg::*;
#(
    parameter int              N          = 4,
    parameter int              WB         = 8,
    parameter int              TB         = 8,
    parameter int              INIT_W     = 0,
    parameter logic [N*N-1:0]  PLAST_MASK = '1,
    localparam int             NN         = N * N,
    localparam int             AW         = $clog2(NN),
    localparam int             IW         = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 spk_valid,
    input  logic [IW-1:0]        spk_idx,
    input  logic [WB-2:0]        dw_pos,
    input  logic [WB-2:0]        dw_neg,
    input  logic [TB-1:0]        t_pre,
    input  logic [TB-1:0]        t_post,
    input  logic [AW-1:0]        wt_raddr,
    output logic signed [WB-1:0] wt_rdata,
    output logic                 done
);

    localparam logic [AW-1:0] LAST_AGE  = AW'(NN - 1);
    localparam logic [AW-1:0] LAST_LINE = AW'(N - 1);

    stdp_state_e state, state_n;
    logic [AW-1:0] cnt, cnt_n;
    logic [IW-1:0] cur, cur_n;

    logic          has_spike;
    logic [IW-1:0] pick_idx;
    logic          take;

    stdp_op_e      op;
    logic          we;
    logic          diag;
    logic [AW-1:0] addr;

    logic signed [WB-1:0] w_rd, w_wr;
    logic [TB-1:0]        pre_rd, pre_wr, post_rd, post_wr;
    logic                 pend_rd, pend_wr, mask_bit;

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        cur_n   = cur;
        unique case (state)
            ST_IDLE: begin
                if (step) begin
                    state_n = ST_AGE;
                    cnt_n   = '0;
                end else if (has_spike) begin
                    state_n = ST_ROW;
                    cnt_n   = '0;
                    cur_n   = pick_idx;
                end
            end
            ST_AGE: begin
                if (cnt == LAST_AGE) state_n = ST_IDLE;
                else                 cnt_n   = cnt + 1'b1;
            end
            ST_ROW: begin
                if (cnt == LAST_LINE) begin
                    state_n = ST_COL;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_COL: begin
                if (cnt == LAST_LINE) state_n = ST_IDLE;
                else                  cnt_n   = cnt + 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            cur   <= cur_n;
        end
    end

    // outputs and memory control
    always_comb begin
        op   = OP_NONE;
        we   = 1'b0;
        diag = 1'b0;
        addr = '0;
        take = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                done = !has_spike;
                take = !step && has_spike;
            end
            ST_AGE: begin
                op   = OP_AGE;
                we   = 1'b1;
                addr = cnt;
            end
            ST_ROW: begin
                op   = OP_ROW;
                we   = 1'b1;
                addr = AW'(int'(cur) * N + int'(cnt));
                diag = int'(cnt) == int'(cur);
            end
            ST_COL: begin
                op   = OP_COL;
                we   = 1'b1;
                addr = AW'(int'(cnt) * N + int'(cur));
                diag = int'(cnt) == int'(cur);
            end
            default: ;
        endcase
    end

    stdp_spike_queue #(.N(N)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld   (spk_valid),
        .set_idx   (spk_idx),
        .take      (take),
        .has_spike (has_spike),
        .pick_idx  (pick_idx)
    );

    stdp_pair_unit #(.WB(WB), .TB(TB)) u_pair (
        .op     (op),
        .diag   (diag),
        .mask   (mask_bit),
        .dw_pos (dw_pos),
        .dw_neg (dw_neg),
        .t_pre  (t_pre),
        .t_post (t_post),
        .w      (w_rd),
        .pre    (pre_rd),
        .post   (post_rd),
        .pend   (pend_rd),
        .w_n    (w_wr),
        .pre_n  (pre_wr),
        .post_n (post_wr),
        .pend_n (pend_wr)
    );

    stdp_syn_store #(
        .N(N), .WB(WB), .TB(TB), .INIT_W(INIT_W), .PLAST_MASK(PLAST_MASK)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .we       (we),
        .w_wr     (w_wr),
        .pre_wr   (pre_wr),
        .post_wr  (post_wr),
        .pend_wr  (pend_wr),
        .w_rd     (w_rd),
        .pre_rd   (pre_rd),
        .post_rd  (post_rd),
        .pend_rd  (pend_rd),
        .mask_rd  (mask_bit),
        .ext_addr (wt_raddr),
        .ext_w    (wt_rdata)
    );

endmodule

// File: rtl/stdp_updater_chk.sv
module stdp_updater_chk
    import stdp_pkg::*;
#(
    parameter int WB = 8,
    parameter int TB = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 step,
    input logic                 spk_valid,
    input logic                 done,
    input stdp_op_e             op,
    input logic                 we,
    input logic                 diag,
    input logic                 mask_bit,
    input logic signed [WB-1:0] w_rd,
    input logic signed [WB-1:0] w_wr,
    input logic [TB-1:0]        pre_wr,
    input logic                 pend_wr,
    input logic [TB-1:0]        t_pre
);

    // R9: an accepted step starts a sweep
    a_r9_step_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (step && done) |=> !done);

    // R9: a reported spike keeps the block busy on the next cycle
    a_r9_spike_busy: assert property (@(posedge clk) disable iff (!rst_n)
        spk_valid |=> !done);

    // R7: a frozen synapse is written back with its stored weight
    a_r7_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !mask_bit) |-> (w_wr == w_rd));

    // R8: diagonal entries keep their weight
    a_r8_diag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && diag) |-> (w_wr == w_rd));

    // R4: aging leaves a trace either disabled or inside the window
    a_r4_age_window: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_AGE) |-> (pre_wr == '1 || pre_wr < t_pre));

    // R5: a row walk re-arms the outgoing trace and its pending bit
    a_r5_row_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_ROW && !diag) |-> (pre_wr == '0 && pend_wr));

endmodule

bind stdp_updater stdp_updater_chk #(.WB(WB), .TB(TB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .spk_valid (spk_valid),
    .done      (done),
    .op        (op),
    .we        (we),
    .diag      (diag),
    .mask_bit  (mask_bit),
    .w_rd      (w_rd),
    .w_wr      (w_wr),
    .pre_wr    (pre_wr),
    .pend_wr   (pend_wr),
    .t_pre     (t_pre)
);

// File: tb/stdp_updater_tb.sv
`timescale 1ns/100ps
module stdp_updater_tb;

    localparam int N  = 4;
    localparam int WB = 8;
    localparam int TB = 8;
    localparam int AW = $clog2(N * N);
    localparam int IW = $clog2(N);

    localparam logic [2:0] K_STEP  = 3'd0;
    localparam logic [2:0] K_SPK   = 3'd1;
    localparam logic [2:0] K_CHK   = 3'd2;
    localparam logic [2:0] K_QUIET = 3'd3;

    // {req[3:0], kind[2:0], arg[7:0], expected weight[7:0]}
    localparam int NV = 56;
    localparam logic [22:0] VEC [NV] = '{
        // R1: traces start disabled, first spike pairs with nothing
        {4'd1, K_STEP, 8'd0, 8'h00}, {4'd1, K_STEP, 8'd0, 8'h00},
        {4'd1, K_SPK, 8'd0, 8'h00},  {4'd1, K_CHK, 8'd4, 8'h00},
        {4'd1, K_CHK, 8'd1, 8'h00},  {4'd1, K_QUIET, 8'd0, 8'h00},
        // R2 / R3: 0 then 1 one step later
        {4'd2, K_STEP, 8'd0, 8'h00}, {4'd2, K_SPK, 8'd0, 8'h00},
        {4'd2, K_STEP, 8'd0, 8'h00}, {4'd2, K_SPK, 8'd1, 8'h00},
        {4'd2, K_CHK, 8'd1, 8'h05},  {4'd3, K_CHK, 8'd4, 8'hFD},
        {4'd2, K_CHK, 8'd2, 8'h00},  {4'd2, K_QUIET, 8'd0, 8'h00},
        // R4: d equal to window gives nothing
        {4'd4, K_STEP, 8'd0, 8'h00}, {4'd4, K_SPK, 8'd2, 8'h00},
        {4'd4, K_STEP, 8'd0, 8'h00}, {4'd4, K_STEP, 8'd0, 8'h00},
        {4'd4, K_STEP, 8'd0, 8'h00}, {4'd4, K_SPK, 8'd3, 8'h00},
        {4'd4, K_CHK, 8'd11, 8'h00}, {4'd4, K_QUIET, 8'd0, 8'h00},
        // R4: same-step spikes never pair
        {4'd4, K_STEP, 8'd0, 8'h00}, {4'd4, K_SPK, 8'd0, 8'h00},
        {4'd4, K_SPK, 8'd2, 8'h00},  {4'd4, K_CHK, 8'd2, 8'h00},
        {4'd4, K_CHK, 8'd8, 8'h00},  {4'd4, K_QUIET, 8'd0, 8'h00},
        // R3 / R2: 3 then 1 two steps later
        {4'd3, K_STEP, 8'd0, 8'h00}, {4'd3, K_SPK, 8'd3, 8'h00},
        {4'd3, K_STEP, 8'd0, 8'h00}, {4'd3, K_STEP, 8'd0, 8'h00},
        {4'd3, K_SPK, 8'd1, 8'h00},  {4'd3, K_CHK, 8'd7, 8'hFD},
        {4'd2, K_CHK, 8'd13, 8'h05}, {4'd3, K_QUIET, 8'd0, 8'h00},
        // R5: second receiver spike does not pair again
        {4'd5, K_STEP, 8'd0, 8'h00}, {4'd5, K_SPK, 8'd0, 8'h00},
        {4'd5, K_STEP, 8'd0, 8'h00}, {4'd5, K_SPK, 8'd1, 8'h00},
        {4'd5, K_CHK, 8'd1, 8'h0A},  {4'd5, K_CHK, 8'd4, 8'hFA},
        {4'd5, K_STEP, 8'd0, 8'h00}, {4'd5, K_SPK, 8'd1, 8'h00},
        {4'd5, K_CHK, 8'd1, 8'h0A},  {4'd5, K_CHK, 8'd4, 8'hFA},
        {4'd5, K_QUIET, 8'd0, 8'h00},
        // R7: synapse 3->2 frozen, 2->3 still learns
        {4'd7, K_STEP, 8'd0, 8'h00}, {4'd7, K_SPK, 8'd3, 8'h00},
        {4'd7, K_STEP, 8'd0, 8'h00}, {4'd7, K_SPK, 8'd2, 8'h00},
        {4'd7, K_CHK, 8'd14, 8'h00}, {4'd7, K_CHK, 8'd11, 8'hFD},
        {4'd7, K_QUIET, 8'd0, 8'h00},
        // R8: self synapses untouched
        {4'd8, K_CHK, 8'd5, 8'h00},  {4'd8, K_CHK, 8'd0, 8'h00}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 step = 1'b0;
    logic                 spk_valid = 1'b0;
    logic [IW-1:0]        spk_idx = '0;
    logic [WB-2:0]        dw_pos = 7'd5;
    logic [WB-2:0]        dw_neg = 7'd3;
    logic [TB-1:0]        t_pre = 8'd3;
    logic [TB-1:0]        t_post = 8'd3;
    logic [AW-1:0]        wt_raddr = '0;
    logic signed [WB-1:0] wt_rdata;
    logic                 done;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    stdp_updater #(
        .N(N), .WB(WB), .TB(TB), .INIT_W(0), .PLAST_MASK(16'hBFFF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .step(step), .spk_valid(spk_valid),
        .spk_idx(spk_idx), .dw_pos(dw_pos), .dw_neg(dw_neg),
        .t_pre(t_pre), .t_post(t_post), .wt_raddr(wt_raddr),
        .wt_rdata(wt_rdata), .done(done)
    );

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_step(output int cyc);
        @(negedge clk);
        step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        wait_done(cyc);
    endtask

    task automatic do_spike(input int idx, output int cyc);
        @(negedge clk);
        spk_valid = 1'b1;
        spk_idx   = IW'(idx);
        @(posedge clk);
        @(negedge clk);
        spk_valid = 1'b0;
        wait_done(cyc);
    endtask

    task automatic chk_w(input int a, input logic signed [WB-1:0] exp, input string tag);
        @(negedge clk);
        wt_raddr = AW'(a);
        #1;
        tests++;
        if (wt_rdata !== exp) begin
            fails++;
            $display("FAIL %s weight[%0d] actual %0d expected %0d", tag, a, wt_rdata, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_int(int'(done), 1, "R1 done after reset");
        for (int a = 0; a < N * N; a++) chk_w(a, 8'sd0, "R1 reset weight");

        // table walk
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VEC[v][22:19], v);
            case (VEC[v][18:16])
                K_STEP:  do_step(cyc);
                K_SPK:   do_spike(int'(VEC[v][15:8]), cyc);
                K_CHK:   chk_w(int'(VEC[v][15:8]), VEC[v][7:0], tag);
                K_QUIET: for (int q = 0; q < 3; q++) do_step(cyc);
                default: ;
            endcase
        end

        // R6: saturation at both limits, synapse 2->1 (addr 9) and 1->2 (addr 6)
        dw_pos = 7'd100;
        for (int r = 0; r < 4; r++) begin
            if (r == 2) dw_neg = 7'd100;
            do_step(cyc);
            do_spike(2, cyc);
            do_step(cyc);
            do_spike(1, cyc);
            chk_w(9, (r == 0) ? 8'sd100 : 8'sd127, "R6 upper limit");
            case (r)
                0: chk_w(6, -8'sd3, "R6 lower limit");
                1: chk_w(6, -8'sd6, "R6 lower limit");
                2: chk_w(6, -8'sd106, "R6 lower limit");
                default: chk_w(6, -8'sd128, "R6 lower limit");
            endcase
            for (int q = 0; q < 3; q++) do_step(cyc);
        end

        // R9: busy lengths
        do_step(cyc);
        chk_int(cyc, N * N, "R9 step sweep cycles");
        do_spike(0, cyc);
        chk_int(cyc, 2 * N + 1, "R9 spike walk cycles");
        chk_int(int'(done), 1, "R9 done after walk");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule